// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block holds the divider settings of a clock synthesizer: a 10-bit feedback divider, a one-bit post-divider, a 3-bit divider for output bank A and a one-bit divider for bank B. It shows them to the analog side as the active configuration and raises a one-cycle strobe whenever that configuration changes. An I2C target port lets a host use two staged configuration bytes and a write-only command register. Commands can move the staged bytes into the active set, copy the active set back into the staged bytes, or step the feedback divider up or down by one. Writing the staged bytes alone never alters the active dividers.

While master reset is low, the active set follows the parallel configuration pins. The value present when reset is released is kept. The board's pull levels on those pins give the default codes: feedback 500, post 1, bank A 3'b010, bank B 0. The mode pin then chooses who owns the active set. When it is low, the set keeps tracking the parallel pins. When it is high, only serial commands change it.

The target FSM has these states: IDLE, ADDR (shift in address), ACK_WAIT (wait for the SCL fall after the 8th bit), ACK_DRV (hold SDA low for the acknowledge), WDATA (shift in a data byte), RDATA (shift out a byte), RACK (sample the host acknowledge), RNEXT (load the next byte on the SCL fall) and SKIP (ignore the bus). The transitions are:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ACK_WAIT on an address match after 8 bits, and to SKIP otherwise.
- ACK_WAIT goes to ACK_DRV on the SCL fall.
- ACK_DRV goes to WDATA or RDATA on the SCL fall.
- WDATA goes to ACK_WAIT after 8 bits.
- RDATA goes to RACK after 8 bits.
- RACK goes to RNEXT on an acknowledge and to SKIP on a NACK.
- RNEXT goes to RDATA on the SCL fall.

Top module: `pll_cfg_i2c`

## Requirements
- R1: The target acknowledges only the 7-bit address {5'b10110, addr_sel[1:0]}. For any other address it never pulls SDA low until the next START.
- R2: A read returns staged byte LO after the address acknowledge, then HI, then LO again, and keeps alternating while the host acknowledges. The command register never appears in read data. After reset both staged bytes read 8'h00.
- R3: In a write, the first data byte goes to LO, the second to HI and the third to the command register. Any further bytes are acknowledged and discarded. None of these writes alone changes the active dividers.
- R4: Layout: LO = fb[7:0] and HI = {post, outb, outa[2:0], fb[9:8], bit0}. HI bit 0 is stored but has no effect. In serial mode, command 8'h01 copies the staged bytes into the active set.
- R5: Command 8'h02 copies the active set into LO/HI using the R4 layout. It works in either mode.
- R6: In serial mode, command 8'h03 adds one to fb and saturates at 1023. Command 8'h04 subtracts one and stops at 0. Neither touches LO/HI. All other codes have no effect.
- R7: While rst_n is low the active set loads from the parallel pins. After release it holds the released value, and apply_stb is 0 in the first cycle after release.
- R8: With ser_mode low, the active set takes new parallel pin values one clock later, and commands 8'h01/8'h03/8'h04 have no effect. With ser_mode high, the parallel pins are ignored.
- R9: apply_stb is high for exactly those cycles in which the active outputs differ from the previous cycle.
- R10: A START seen in the middle of a byte restarts address reception. A STOP in the middle of a byte drops that byte, returns to IDLE and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low; release captures the parallel pins |
| ser_mode | input | 1 | 1: serial control, 0: parallel pins drive the active set |
| addr_sel | input | 2 | Low two bits of the target address |
| par_fb | input | 10 | Parallel feedback divider code |
| par_outa | input | 3 | Parallel bank A divider code |
| par_outb | input | 1 | Parallel bank B divider code |
| par_post | input | 1 | Parallel post-divider code |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| act_fb | output | 10 | Active feedback divider |
| act_outa | output | 3 | Active bank A divider |
| act_outb | output | 1 | Active bank B divider |
| act_post | output | 1 | Active post-divider |
| apply_stb | output | 1 | One-cycle pulse on any active change |

## Verification
The hardest case to reach is one where the staged bytes and the active dividers disagree, and the disagreement can only be seen through the serial port itself. The stimulus loads a configuration, steps the feedback divider with the increment command, and reads the staged bytes back unchanged. It then issues the copy-back command and reads the stepped value. Aborted bytes are also hard to reach. The bench cuts transfers after a few bits with a repeated START or a STOP, then proves through a later read that the aborted bytes left the staged bytes untouched.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int FB_W   = 10;
    localparam int OUTA_W = 3;

    typedef struct packed {
        logic              post;
        logic              outb;
        logic [OUTA_W-1:0] outa;
        logic [FB_W-1:0]   fb;
    } div_cfg_t;

    localparam logic [7:0] CMD_LOAD = 8'h01;
    localparam logic [7:0] CMD_GET  = 8'h02;
    localparam logic [7:0] CMD_INC  = 8'h03;
    localparam logic [7:0] CMD_DEC  = 8'h04;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ACK_WAIT, ST_ACK_DRV, ST_WDATA,
        ST_RDATA, ST_RACK, ST_RNEXT, ST_SKIP
    } tgt_state_e;

    function automatic logic [7:0] pack_lo(input div_cfg_t c);
        return c.fb[7:0];
    endfunction

    function automatic logic [7:0] pack_hi(input div_cfg_t c);
        return {c.post, c.outb, c.outa, c.fb[9:8], 1'b0};
    endfunction

    function automatic div_cfg_t unpack(input logic [7:0] lo, input logic [7:1] hi);
        div_cfg_t u;
        u.fb   = {hi[2:1], lo};
        u.outa = hi[5:3];
        u.outb = hi[6];
        u.post = hi[7];
        return u;
    endfunction

endpackage

// File: rtl/pcfg_line_cond.sv
module pcfg_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_q, sda_q;
    logic         scl_p, sda_p, scl_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[TOP-1:0], scl_in};
            sda_q <= {sda_q[TOP-1:0], sda_in};
            scl_p <= scl_q[TOP];
            sda_p <= sda_q[TOP];
        end
    end

    assign scl_s    = scl_q[TOP];
    assign sda_s    = sda_q[TOP];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pcfg_tgt_fsm.sv
module pcfg_tgt_fsm
    import pcfg_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b10110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_sel,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_byte,
    output logic       rd_sel,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [1:0] wr_idx,
    output logic [7:0] wr_data
);
    tgt_state_e state;
    logic [2:0] cnt;
    logic [7:0] sh;
    logic [1:0] bidx;
    logic       is_rd;
    logic [7:0] byte_in;

    assign byte_in = {sh[6:0], sda_s};

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            bidx  <= '0;
            is_rd <= 1'b0;
        end else if (start_ev) begin
            state <= ST_ADDR;
            cnt   <= '0;
            bidx  <= '0;
        end else if (stop_ev) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_ADDR: if (scl_rise) begin
                    sh  <= byte_in;
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        if (byte_in[7:1] == {ADDR_HI, addr_sel}) begin
                            state <= ST_ACK_WAIT;
                            is_rd <= sda_s;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_WDATA: if (scl_rise) begin
                    sh  <= byte_in;
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        state <= ST_ACK_WAIT;
                        if (bidx != 2'd3) bidx <= bidx + 2'd1;
                    end
                end
                ST_ACK_WAIT: if (scl_fall) state <= ST_ACK_DRV;
                ST_ACK_DRV: if (scl_fall) begin
                    cnt <= '0;
                    if (is_rd) begin
                        state <= ST_RDATA;
                        sh    <= rd_byte;
                        bidx  <= bidx + 2'd1;
                    end else begin
                        state <= ST_WDATA;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    sh  <= {sh[6:0], 1'b1};
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) state <= ST_RACK;
                end
                ST_RACK: if (scl_rise) state <= sda_s ? ST_SKIP : ST_RNEXT;
                ST_RNEXT: if (scl_fall) begin
                    state <= ST_RDATA;
                    cnt   <= '0;
                    sh    <= rd_byte;
                    bidx  <= bidx + 2'd1;
                end
                ST_IDLE, ST_SKIP: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_stb = 1'b0;
        unique case (state)
            ST_ACK_DRV: sda_oe = 1'b1;
            ST_RDATA:   sda_oe = ~sh[7];
            ST_WDATA:   wr_stb = scl_rise & (cnt == 3'd7) & ~start_ev & ~stop_ev;
            default: ;
        endcase
        wr_idx  = bidx;
        wr_data = byte_in;
        rd_sel  = bidx[0];
    end
endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
    import pcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_mode,
    input  div_cfg_t   par_cfg,
    input  logic       wr_stb,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_byte,
    output div_cfg_t   act,
    output logic       apply_stb
);
    logic [7:0] stg_lo, stg_hi;
    div_cfg_t   act_nxt;
    logic       cmd_stb;

    assign cmd_stb = wr_stb && (wr_idx == 2'd2);

    always_comb begin
        act_nxt = act;
        if (!ser_mode) begin
            act_nxt = par_cfg;
        end else if (cmd_stb) begin
            case (wr_data)
                CMD_LOAD: act_nxt = unpack(stg_lo, stg_hi[7:1]);
                CMD_INC:  if (act.fb != '1) act_nxt.fb = act.fb + 1'b1;
                CMD_DEC:  if (act.fb != '0) act_nxt.fb = act.fb - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act       <= par_cfg;
            apply_stb <= 1'b0;
            stg_lo    <= '0;
            stg_hi    <= '0;
        end else begin
            act       <= act_nxt;
            apply_stb <= (act_nxt != act);
            if (wr_stb) begin
                case (wr_idx)
                    2'd0: stg_lo <= wr_data;
                    2'd1: stg_hi <= wr_data;
                    2'd2: if (wr_data == CMD_GET) begin
                        stg_lo <= pack_lo(act);
                        stg_hi <= pack_hi(act);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_byte = rd_sel ? stg_hi : stg_lo;
endmodule

// File: rtl/pll_cfg_i2c.sv
module pll_cfg_i2c
    import pcfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_HI     = 5'b10110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic [1:0]        addr_sel,
    input  logic [FB_W-1:0]   par_fb,
    input  logic [OUTA_W-1:0] par_outa,
    input  logic              par_outb,
    input  logic              par_post,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [FB_W-1:0]   act_fb,
    output logic [OUTA_W-1:0] act_outa,
    output logic              act_outb,
    output logic              act_post,
    output logic              apply_stb
);
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_stb, rd_sel;
    logic [1:0] wr_idx;
    logic [7:0] wr_data, rd_byte;
    div_cfg_t   par_cfg, act;

    assign par_cfg = {par_post, par_outb, par_outa, par_fb};

    pcfg_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    pcfg_tgt_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .rd_byte(rd_byte), .rd_sel(rd_sel),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    pcfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .par_cfg(par_cfg),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_byte(rd_byte), .act(act), .apply_stb(apply_stb)
    );

    assign act_fb   = act.fb;
    assign act_outa = act.outa;
    assign act_outb = act.outb;
    assign act_post = act.post;
endmodule

// File: rtl/pll_cfg_i2c_chk.sv
module pll_cfg_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ser_mode,
    input logic [9:0] act_fb,
    input logic [2:0] act_outa,
    input logic       act_outb,
    input logic       act_post,
    input logic       apply_stb,
    input logic       sda_oe,
    input logic       stop_ev,
    input logic       wr_stb,
    input logic [1:0] wr_idx,
    input logic [7:0] wr_data
);
    logic [14:0] act_v;
    assign act_v = {act_post, act_outb, act_outa, act_fb};

    // R9
    apply_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (apply_stb == (act_v != $past(act_v))));

    // R8
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ser_mode) && !$past(wr_stb)) |-> $stable(act_v));

    // R6
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ser_mode) && $past(wr_stb) && $past(wr_idx) == 2'd2
         && $past(wr_data) == 8'h03 && $past(act_fb) != 10'h3FF)
        |-> act_fb == $past(act_fb) + 10'd1);

    // R6
    dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ser_mode) && $past(wr_stb) && $past(wr_idx) == 2'd2
         && $past(wr_data) == 8'h04 && $past(act_fb) == 10'd0)
        |-> act_fb == 10'd0);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_ev) |-> !sda_oe);
endmodule

bind pll_cfg_i2c pll_cfg_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .act_fb(act_fb),
    .act_outa(act_outa), .act_outb(act_outb), .act_post(act_post),
    .apply_stb(apply_stb), .sda_oe(sda_oe), .stop_ev(stop_ev),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/sim_pll_cfg_i2c.sv
module sim_pll_cfg_i2c;
    localparam int Q = 6;
    localparam int H = 8;
    localparam int NV = 11;
    // {lo, hi, cmd, exp post, exp outb, exp outa, exp fb}
    localparam logic [38:0] VEC [NV] = '{
        {8'h64, 8'hE8, 8'h01, 1'b1, 1'b1, 3'd5, 10'd100},
        {8'h00, 8'h00, 8'h03, 1'b1, 1'b1, 3'd5, 10'd101},
        {8'h00, 8'h00, 8'h04, 1'b1, 1'b1, 3'd5, 10'd100},
        {8'h00, 8'h00, 8'h7F, 1'b1, 1'b1, 3'd5, 10'd100},
        {8'hFF, 8'h1E, 8'h01, 1'b0, 1'b0, 3'd3, 10'd1023},
        {8'hFF, 8'h1E, 8'h03, 1'b0, 1'b0, 3'd3, 10'd1023},
        {8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0, 10'd0},
        {8'h00, 8'h00, 8'h04, 1'b0, 1'b0, 3'd0, 10'd0},
        {8'h34, 8'h94, 8'h00, 1'b0, 1'b0, 3'd0, 10'd0},
        {8'h34, 8'h94, 8'h01, 1'b1, 1'b0, 3'd2, 10'd564},
        {8'h34, 8'h94, 8'h03, 1'b1, 1'b0, 3'd2, 10'd565}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_mode = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic [9:0] par_fb = 10'd500;
    logic [2:0] par_outa = 3'b010;
    logic par_outb = 1'b0;
    logic par_post = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, apply_stb, act_outb, act_post;
    logic [9:0] act_fb;
    logic [2:0] act_outa;
    logic sda_line;
    logic [14:0] act_v;
    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;

    assign sda_line = m_sda & ~sda_oe;
    assign act_v = {act_post, act_outb, act_outa, act_fb};

    always #2.5 clk = ~clk;

    pll_cfg_i2c u0 (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .addr_sel(addr_sel),
        .par_fb(par_fb), .par_outa(par_outa), .par_outb(par_outb), .par_post(par_post),
        .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe), .act_fb(act_fb),
        .act_outa(act_outa), .act_outb(act_outb), .act_post(act_post),
        .apply_stb(apply_stb)
    );

    always @(posedge clk) if (rst_n && apply_stb) stb_cnt <= stb_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(2);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) clk_bit(v[7-i]);
    endtask

    task automatic i2c_wr(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
        ack = !sda_line;
        tick(H/2); m_scl = 1'b0; tick(2);
    endtask

    task automatic i2c_rd(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); m_scl = 1'b1; tick(H/2);
            b[7-i] = sda_line;
            tick(H/2); m_scl = 1'b0; tick(2);
        end
        m_sda = mack ? 1'b0 : 1'b1;
        tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input bit rd);
        return {5'b10110, addr_sel, rd};
    endfunction

    task automatic cfg_write(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] cmd, output bit ack_all);
        bit a0, a1, a2, a3;
        i2c_start;
        i2c_wr(addr_byte(1'b0), a0);
        i2c_wr(lo, a1); i2c_wr(hi, a2); i2c_wr(cmd, a3);
        i2c_stop; tick(4);
        ack_all = a0 & a1 & a2 & a3;
    endtask

    task automatic cfg_read(output logic [7:0] lo, output logic [7:0] hi);
        bit a;
        i2c_start;
        i2c_wr(addr_byte(1'b1), a);
        i2c_rd(1'b1, lo); i2c_rd(1'b0, hi);
        i2c_stop; tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] lo, hi, b2;
        bit ack;
        int s0;
        logic [14:0] prev;

        // R7: reset capture of pull defaults
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk(apply_stb == 1'b0, "R7 strobe after release", apply_stb, 0);
        chk(act_v == {1'b1, 1'b0, 3'b010, 10'd500}, "R7 default capture", act_v, {1'b1, 1'b0, 3'b010, 10'd500});
        // R8: serial mode ignores the pins
        par_fb = 10'd9; par_outa = 3'd7;
        tick(5);
        chk(act_fb == 10'd500 && act_outa == 3'b010, "R8 pins ignored in serial mode", act_v, {1'b1, 1'b0, 3'b010, 10'd500});
        // R2: staged bytes empty after reset
        cfg_read(lo, hi);
        chk({lo, hi} == 16'h0000, "R2 staged reset value", {lo, hi}, 16'h0000);
        // R5: copy back
        cfg_write(8'hAA, 8'h55, 8'h02, ack);
        cfg_read(lo, hi);
        chk({lo, hi} == 16'hF492, "R5 copy back of startup set", {lo, hi}, 16'hF492);

        // vector table: R3 R4 R6 R9
        prev = act_v;
        for (int v = 0; v < NV; v++) begin
            s0 = stb_cnt;
            cfg_write(VEC[v][38:31], VEC[v][30:23], VEC[v][22:15], ack);
            chk(ack, "R1/R3 bytes acknowledged", ack, 1);
            chk(act_v == VEC[v][14:0], "R4/R6 active after command", act_v, VEC[v][14:0]);
            chk((stb_cnt - s0) == ((VEC[v][14:0] != prev) ? 1 : 0), "R9 strobe count", stb_cnt - s0, (VEC[v][14:0] != prev) ? 1 : 0);
            prev = VEC[v][14:0];
        end
        // R6: increment left the staged bytes alone
        cfg_read(lo, hi);
        chk({lo, hi} == 16'h3494, "R6 staged untouched by step", {lo, hi}, 16'h3494);
        cfg_write(8'h00, 8'h00, 8'h02, ack);
        cfg_read(lo, hi);
        chk({lo, hi} == 16'h3594, "R5 copy back after step", {lo, hi}, 16'h3594);

        // R3: extra byte discarded; staged writes alone leave the active set
        i2c_start;
        i2c_wr(addr_byte(1'b0), ack);
        i2c_wr(8'h11, ack); i2c_wr(8'h22, ack); i2c_wr(8'h00, ack); i2c_wr(8'h01, ack);
        chk(ack, "R3 fourth byte acknowledged", ack, 1);
        i2c_stop; tick(4);
        chk(act_fb == 10'd565, "R3 staged write keeps active", act_fb, 565);
        // R2: three byte read alternates
        i2c_start;
        i2c_wr(addr_byte(1'b1), ack);
        i2c_rd(1'b1, lo); i2c_rd(1'b1, hi); i2c_rd(1'b0, b2);
        i2c_stop; tick(4);
        chk({lo, hi, b2} == 24'h112211, "R2 read order", {lo, hi, b2}, 24'h112211);

        // R1: other address ignored, other addr_sel accepted
        i2c_start;
        i2c_wr(8'hB6, ack);
        chk(!ack, "R1 foreign address not acknowledged", ack, 0);
        i2c_stop; tick(4);
        addr_sel = 2'b01;
        i2c_start;
        i2c_wr(8'hB2, ack);
        chk(ack, "R1 address follows addr_sel", ack, 1);
        i2c_stop; tick(4);

        // R10: START mid-byte, then full write
        i2c_start;
        send_bits(8'hA0, 4);
        cfg_write(8'h55, 8'h00, 8'h00, ack);
        chk(ack, "R10 restart after START mid-byte", ack, 1);
        // R10: STOP mid-byte drops the byte
        i2c_start;
        i2c_wr(addr_byte(1'b0), ack);
        send_bits(8'h00, 3);
        i2c_stop; tick(4);
        chk(sda_oe == 1'b0, "R10 bus released after STOP", sda_oe, 0);
        cfg_read(lo, hi);
        chk(lo == 8'h55, "R10 aborted byte not stored", lo, 8'h55);

        // R8: parallel mode tracking
        ser_mode = 1'b0;
        par_fb = 10'd7; par_outa = 3'd1; par_outb = 1'b1; par_post = 1'b0;
        s0 = stb_cnt;
        tick(3);
        chk(act_v == {1'b0, 1'b1, 3'd1, 10'd7}, "R8 active follows pins", act_v, {1'b0, 1'b1, 3'd1, 10'd7});
        chk(stb_cnt - s0 == 1, "R9 one strobe on pin change", stb_cnt - s0, 1);
        cfg_write(8'h64, 8'hE8, 8'h01, ack);
        chk(act_fb == 10'd7, "R8 load ignored in parallel mode", act_fb, 7);
        cfg_write(8'h00, 8'h00, 8'h03, ack);
        chk(act_fb == 10'd7, "R8 step ignored in parallel mode", act_fb, 7);
        cfg_write(8'h00, 8'h00, 8'h02, ack);
        cfg_read(lo, hi);
        chk({lo, hi} == 16'h0748, "R5 copy back in parallel mode", {lo, hi}, 16'h0748);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule